// File: doc/BRIEF.md
# Register-to-NAND Flash Bridge

The bridge is a bus slave with a single 32-bit register, and it drives an 8-bit raw NAND flash. Every host write to the register names an operation in a three-bit field. The operation can be a command latch, an address latch, a data-byte write, or entry into read mode. For each write-type operation the bridge runs one flash strobe cycle. In that cycle it sets CLE, ALE and chip enable, drives the byte on the I/O bus, and pulses the write strobe with timed low and high phases.

After the host has entered read mode, each host read of the register pulses the read strobe once. The read returns the next flash byte in the same byte field that writes use. Every read also reports the flash ready/busy pin, taken through a two-flop synchronizer. While a strobe cycle runs, the bridge holds off the host by keeping its ready low. The host keeps `bus_sel` asserted until it sees a one-cycle `bus_ready` pulse, and it drops `bus_sel` before the next clock edge.

Top module: `nand_reg_bridge`

## Requirements
- R1: After reset, `flash_ce_n`, `flash_we_n` and `flash_re_n` are high, `flash_cle`, `flash_ale`, `flash_io_oe` and `bus_ready` are low, and a status read returns 0 in bits [23:16].
- R2: A write with op field bits [30:28] = 0 produces exactly one write-strobe pulse. During it CLE is high, ALE is low, and `flash_io_out` equals write bits [23:16] at the rising edge of the strobe.
- R3: Op 1 produces one write-strobe pulse with ALE high, CLE low, and the byte from bits [23:16].
- R4: Op 3 produces one write-strobe pulse with CLE and ALE both low, and the byte from bits [23:16]. Each write transfers one byte only.
- R5: Bit 31 of a write (or of the read-mode write, for later fetches) drives `flash_ce_n` low for the cycle. If bit 31 is 0, `flash_ce_n` stays high.
- R6: The strobe stays low for LOW_CLKS clocks and then high for HIGH_CLKS clocks. The output byte holds across the rising edge. `bus_ready` pulses 2+LOW_CLKS+HIGH_CLKS clocks after the request is accepted (6 with the defaults).
- R7: Op 2 is acknowledged after one clock and produces no strobe. After it, each host read produces one read-strobe pulse and returns the next sequential flash byte in bits [23:16]. The byte is sampled on the last clock of the low phase.
- R8: Any op other than 2 clears read mode. A later read is then acknowledged after one clock, produces no read strobe, and returns 0 in bits [23:16].
- R9: Ops 4 to 7 produce no flash cycle and are acknowledged after one clock.
- R10: Read bit 15 is 1 when `flash_rb_n` is low (busy) and 0 when it is high, after a two-flop synchronizer.
- R11: `flash_io_oe` is high only during write-type cycles and never while the read strobe is low.
- R12: `bus_ready` is high for exactly one clock per accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request, held until bus_ready |
| bus_wr | input | 1 | 1 = register write, 0 = register read |
| bus_wdata | input | 32 | Write word: [31] chip enable, [30:28] op, [23:16] byte |
| bus_rdata | output | 32 | Read word: [23:16] fetched byte, [15] busy |
| bus_ready | output | 1 | One-cycle completion pulse |
| flash_cle | output | 1 | Command latch enable |
| flash_ale | output | 1 | Address latch enable |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_re_n | output | 1 | Read strobe, active low |
| flash_io_out | output | 8 | Byte driven to flash |
| flash_io_oe | output | 1 | Output enable for the I/O bus |
| flash_io_in | input | 8 | Byte from flash |
| flash_rb_n | input | 1 | Ready/busy pin, low = busy |

## Verification
Directed accesses run the command, address and data ops with chip enable both set and clear. This separates the CLE, ALE and enable mappings and confirms the exact strobe low width and acknowledge latency. A read-mode sequence against a flash model whose byte changes with every strobe shows that each read advances by exactly one byte. A reserved op sent after read mode shows that the mode is cleared. A seeded random mix of all eight op codes, interleaved with reads, is checked against a bench model of read mode, strobe counts and latched bytes. The ready/busy pin is toggled in both directions to check the polarity of bit 15.

// File: rtl/nrb_pkg.sv
// Package: shared field positions and phase type for the NAND register bridge.
// Assumes a 32-bit register word with fixed field positions.
package nrb_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned CE_BIT   = 31;
    localparam int unsigned OP_LSB   = 28;
    localparam int unsigned BYTE_LSB = 16;
    localparam int unsigned BUSY_BIT = 15;

    localparam logic [2:0] OP_CMD    = 3'd0;
    localparam logic [2:0] OP_ADDR   = 3'd1;
    localparam logic [2:0] OP_RDMODE = 3'd2;
    localparam logic [2:0] OP_WRDATA = 3'd3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_HIGH  = 2'd3
    } phase_t;
endpackage

// File: rtl/nrb_sync.sv
// Module: two-flop synchronizer for a single asynchronous level.
// Assumes the input is a slow level; resets to RST_VAL.
module nrb_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    // Two stages resolve metastability before use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/nrb_decode.sv
// Module: combinational decode of a host register write word.
// Assumes op codes 4..7 are reserved and trigger nothing.
module nrb_decode
    import nrb_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              is_xfer,
    output logic              is_rdmode,
    output logic              cle,
    output logic              ale,
    output logic              ce_req,
    output logic [BYTE_W-1:0] data_byte
);
    logic [2:0] op;

    // Split fields and classify the operation.
    always_comb begin
        op        = word[OP_LSB +: 3];
        ce_req    = word[CE_BIT];
        data_byte = word[BYTE_LSB +: BYTE_W];
        cle       = (op == OP_CMD);
        ale       = (op == OP_ADDR);
        is_xfer   = (op == OP_CMD) || (op == OP_ADDR) || (op == OP_WRDATA);
        is_rdmode = (op == OP_RDMODE);
    end
endmodule

// File: rtl/nrb_strobe.sv
// Module: strobe timing engine: one setup clock, LOW_CLKS low, HIGH_CLKS high.
// Assumes start is only raised while the engine is idle.
module nrb_strobe
    import nrb_pkg::*;
#(
    parameter int unsigned LOW_CLKS  = 2,
    parameter int unsigned HIGH_CLKS = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_t phase,
    output logic   sample,
    output logic   done
);
    localparam int unsigned MAXC = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CLKS - 1);
    localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CLKS - 1);

    logic [CW-1:0] cnt;

    // Last clock of each phase.
    assign sample = (phase == PH_LOW)  && (cnt == LOW_LAST);
    assign done   = (phase == PH_HIGH) && (cnt == HIGH_LAST);

    // Advance through setup, low and high phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE:  if (start) phase <= PH_SETUP;
                PH_SETUP: begin phase <= PH_LOW; cnt <= '0; end
                PH_LOW:   if (sample) begin phase <= PH_HIGH; cnt <= '0; end
                          else cnt <= cnt + 1'b1;
                PH_HIGH:  if (done) begin phase <= PH_IDLE; cnt <= '0; end
                          else cnt <= cnt + 1'b1;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    assert_start_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (phase == PH_IDLE));
endmodule

// File: rtl/nand_reg_bridge.sv
// Module: single-register bridge from a host bus to an 8-bit raw NAND flash.
// Assumes the host holds bus_sel until bus_ready and drops it right after.
module nand_reg_bridge
    import nrb_pkg::*;
#(
    parameter int unsigned LOW_CLKS  = 2,
    parameter int unsigned HIGH_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              flash_cle,
    output logic              flash_ale,
    output logic              flash_ce_n,
    output logic              flash_we_n,
    output logic              flash_re_n,
    output logic [BYTE_W-1:0] flash_io_out,
    output logic              flash_io_oe,
    input  logic [BYTE_W-1:0] flash_io_in,
    input  logic              flash_rb_n
);
    logic              d_xfer, d_rdmode, d_cle, d_ale, d_ce;
    logic [BYTE_W-1:0] d_byte;
    phase_t            phase;
    logic              sample, done, start, accept, active, rb_n_s;
    logic              cle_q, ale_q, ce_q, rd_q, rdmode_q, rdce_q;
    logic [BYTE_W-1:0] byte_q, cap_q;

    nrb_decode u_dec (
        .word(bus_wdata), .is_xfer(d_xfer), .is_rdmode(d_rdmode),
        .cle(d_cle), .ale(d_ale), .ce_req(d_ce), .data_byte(d_byte)
    );

    nrb_strobe #(.LOW_CLKS(LOW_CLKS), .HIGH_CLKS(HIGH_CLKS)) u_strobe (
        .clk(clk), .rst_n(rst_n), .start(start),
        .phase(phase), .sample(sample), .done(done)
    );

    nrb_sync #(.RST_VAL(1'b1)) u_rb_sync (
        .clk(clk), .rst_n(rst_n), .d_async(flash_rb_n), .q_sync(rb_n_s)
    );

    // Accept a new access only when idle and not in the acknowledge cycle.
    assign active = (phase != PH_IDLE);
    assign accept = bus_sel && !bus_ready && !active;
    assign start  = accept && (bus_wr ? d_xfer : rdmode_q);

    // Flash pins follow the latched cycle attributes while a cycle runs.
    assign flash_cle    = active && cle_q;
    assign flash_ale    = active && ale_q;
    assign flash_ce_n   = !(active && ce_q);
    assign flash_we_n   = !((phase == PH_LOW) && !rd_q);
    assign flash_re_n   = !((phase == PH_LOW) && rd_q);
    assign flash_io_oe  = active && !rd_q;
    assign flash_io_out = byte_q;

    // Latch cycle attributes, track read mode, capture data, build response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cle_q     <= 1'b0;
            ale_q     <= 1'b0;
            ce_q      <= 1'b0;
            rd_q      <= 1'b0;
            rdmode_q  <= 1'b0;
            rdce_q    <= 1'b0;
            byte_q    <= '0;
            cap_q     <= '0;
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= 1'b0;
            if (sample && rd_q) cap_q <= flash_io_in;
            if (accept) begin
                bus_rdata <= '0;
                bus_rdata[BUSY_BIT] <= !rb_n_s;
                if (bus_wr) begin
                    rdmode_q <= d_rdmode;
                    if (d_rdmode) rdce_q <= d_ce;
                    if (d_xfer) begin
                        cle_q  <= d_cle;
                        ale_q  <= d_ale;
                        ce_q   <= d_ce;
                        rd_q   <= 1'b0;
                        byte_q <= d_byte;
                    end else begin
                        bus_ready <= 1'b1;
                    end
                end else if (rdmode_q) begin
                    cle_q <= 1'b0;
                    ale_q <= 1'b0;
                    ce_q  <= rdce_q;
                    rd_q  <= 1'b1;
                end else begin
                    bus_ready <= 1'b1;
                end
            end
            if (done) begin
                bus_ready <= 1'b1;
                bus_rdata <= '0;
                bus_rdata[BUSY_BIT] <= !rb_n_s;
                if (rd_q) bus_rdata[BYTE_LSB +: BYTE_W] <= cap_q;
            end
        end
    end

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !flash_re_n));
    assert_hold_across_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |=> $stable(flash_io_out));
    assert_no_drive_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flash_io_oe |-> flash_re_n);
    assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);
    assert_latch_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_cle && flash_ale));
endmodule

// File: tb/nand_reg_bridge_tb.sv
// Bench: directed and seeded-random accesses against a bench model of the bridge.
module nand_reg_bridge_tb;
    localparam int LOWC = 2;
    localparam int HIGHC = 2;
    localparam int CYC_LAT = 2 + LOWC + HIGHC;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic bus_ready, flash_cle, flash_ale, flash_ce_n, flash_we_n, flash_re_n, flash_io_oe;
    logic [7:0] flash_io_out, flash_io_in;
    logic flash_rb_n = 1'b1;

    int vectors = 0, miscompares = 0;
    int we_pulses = 0, re_pulses = 0, rd_ptr = 0, low_len = 0, last_low = 0, oe_bad = 0;
    logic [7:0] log_byte;
    logic log_cle, log_ale, log_cen;
    logic we_prev = 1'b1, re_prev = 1'b1;

    always #10 clk = ~clk;

    nand_reg_bridge #(.LOW_CLKS(LOWC), .HIGH_CLKS(HIGHC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .flash_cle(flash_cle), .flash_ale(flash_ale), .flash_ce_n(flash_ce_n),
        .flash_we_n(flash_we_n), .flash_re_n(flash_re_n), .flash_io_out(flash_io_out),
        .flash_io_oe(flash_io_oe), .flash_io_in(flash_io_in), .flash_rb_n(flash_rb_n)
    );

    function automatic logic [7:0] flash_byte(input int idx);
        return 8'(idx * 37 + 5);
    endfunction

    function automatic logic [31:0] mk_word(input logic ce, input logic [2:0] op, input logic [7:0] b);
        return {ce, op, 4'h0, b, 16'h0};
    endfunction

    assign flash_io_in = flash_byte(rd_ptr);

    // Flash-side monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (!flash_we_n || !flash_re_n) low_len <= low_len + 1;
        if (!flash_re_n && flash_io_oe) oe_bad <= oe_bad + 1;
        if (!we_prev && flash_we_n) begin
            we_pulses <= we_pulses + 1;
            log_byte <= flash_io_out; log_cle <= flash_cle;
            log_ale <= flash_ale; log_cen <= flash_ce_n;
            last_low <= low_len; low_len <= 0;
        end
        if (!re_prev && flash_re_n) begin
            re_pulses <= re_pulses + 1; rd_ptr <= rd_ptr + 1;
            last_low <= low_len; low_len <= 0;
        end
        we_prev <= flash_we_n; re_prev <= flash_re_n;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [31:0] w, output logic [31:0] rd, output int lat);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_wdata = w; lat = 0;
        do begin @(negedge clk); lat++; end while (!bus_ready && lat < 100);
        rd = bus_rdata;
        bus_sel = 1'b0;
        @(negedge clk);
        check(!bus_ready, "R12", {31'h0, bus_ready}, 32'h0);
    endtask

    task automatic do_write(input logic ce, input logic [2:0] op, input logic [7:0] b, input string req);
        logic [31:0] rd; int lat; int wp0;
        wp0 = we_pulses;
        access(1'b1, mk_word(ce, op, b), rd, lat);
        if (op == 3'd0 || op == 3'd1 || op == 3'd3) begin
            check(lat == CYC_LAT, "R6", 32'(lat), 32'(CYC_LAT));
            check(we_pulses == wp0 + 1, req, 32'(we_pulses - wp0), 32'h1);
            check(log_byte == b, req, {24'h0, log_byte}, {24'h0, b});
            check(log_cle == (op == 3'd0) && log_ale == (op == 3'd1), req,
                  {30'h0, log_cle, log_ale}, {30'h0, op == 3'd0, op == 3'd1});
            check(log_cen == !ce, "R5", {31'h0, log_cen}, {31'h0, !ce});
            check(last_low == LOWC, "R6", 32'(last_low), 32'(LOWC));
        end else begin
            check(lat == 1, req, 32'(lat), 32'h1);
            check(we_pulses == wp0, req, 32'(we_pulses - wp0), 32'h0);
        end
    endtask

    task automatic do_read(input logic rdmode, input string req);
        logic [31:0] rd; int lat; int rp0; logic [7:0] expb;
        rp0 = re_pulses; expb = flash_byte(rd_ptr);
        access(1'b0, 32'h0, rd, lat);
        if (rdmode) begin
            check(lat == CYC_LAT, req, 32'(lat), 32'(CYC_LAT));
            check(re_pulses == rp0 + 1, req, 32'(re_pulses - rp0), 32'h1);
            check(rd[23:16] == expb, req, {24'h0, rd[23:16]}, {24'h0, expb});
        end else begin
            check(lat == 1, req, 32'(lat), 32'h1);
            check(re_pulses == rp0, req, 32'(re_pulses - rp0), 32'h0);
            check(rd[23:16] == 8'h0, req, {24'h0, rd[23:16]}, 32'h0);
        end
    endtask

    initial begin
        int seed_dummy;
        logic rm;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check({flash_ce_n, flash_we_n, flash_re_n, flash_cle, flash_ale, flash_io_oe, bus_ready} == 7'b1110000,
              "R1", {25'h0, flash_ce_n, flash_we_n, flash_re_n, flash_cle, flash_ale, flash_io_oe, bus_ready}, 32'h70);
        do_read(1'b0, "R1");

        do_write(1'b1, 3'd0, 8'h90, "R2");
        do_write(1'b1, 3'd1, 8'h00, "R3");
        do_write(1'b0, 3'd3, 8'hA5, "R4");
        do_write(1'b0, 3'd0, 8'hFF, "R5");

        do_write(1'b1, 3'd2, 8'h00, "R7");
        for (int i = 0; i < 4; i++) do_read(1'b1, "R7");
        do_write(1'b1, 3'd5, 8'h11, "R9");
        do_read(1'b0, "R8");
        do_write(1'b1, 3'd2, 8'h00, "R7");
        do_write(1'b1, 3'd3, 8'h22, "R8");
        do_read(1'b0, "R8");
        for (int op = 4; op < 8; op++) do_write(1'b1, 3'(op), 8'h5A, "R9");

        // R10: busy polarity through the synchronizer.
        begin
            logic [31:0] rd; int lat;
            flash_rb_n = 1'b0; repeat (3) @(negedge clk);
            access(1'b0, 32'h0, rd, lat);
            check(rd[15] == 1'b1, "R10", {31'h0, rd[15]}, 32'h1);
            flash_rb_n = 1'b1; repeat (3) @(negedge clk);
            access(1'b0, 32'h0, rd, lat);
            check(rd[15] == 1'b0, "R10", {31'h0, rd[15]}, 32'h0);
        end

        // Random mix against the read-mode model.
        rm = 1'b0;
        for (int n = 0; n < 80; n++) begin
            logic [2:0] op; logic ce; logic [7:0] b;
            op = 3'($urandom_range(0, 7)); ce = 1'($urandom); b = 8'($urandom);
            if ($urandom_range(0, 2) == 0) do_read(rm, rm ? "R7" : "R8");
            else begin
                do_write(ce, op, b, (op < 4) ? "R4" : "R9");
                rm = (op == 3'd2);
            end
        end

        check(oe_bad == 0, "R11", 32'(oe_bad), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule